// File: doc/BRIEF.md
# FIFO Flag Offset Register Port

This block keeps the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against. Software loads them over the FIFO's byte-wide write data bus in the write clock domain. It reads them back over the byte-wide read data path in the read clock domain. An active-low load select, qualified by the write enable or the read enable, steers a transfer to these registers instead of the FIFO memory. With the load select inactive, the enables pass through to the memory side and the offsets stay as they are.

Each offset is wider than a byte, so it moves as two bytes. A two-bit position counter walks a fixed four-step cycle: almost-empty low byte, almost-empty high byte, almost-full low byte, almost-full high byte. It then wraps back to the first position, so a new load can start without a reset. Loading and readback each keep their own position counter, one in each clock domain. A master reset returns both counters to the first position and sets both offsets to a parameterised default, 127 unless overridden.

Readback bytes pass through an output register. They appear on the data output only while the active-low output enable is low. Otherwise the output floats.

Top module: `ofs_regport`

## Requirements
- R1: After a master reset (`mrst_n` low at a clock edge), both offsets equal `DEF_OFS` (127), both position counters are at the almost-empty low byte, and the output register holds 0.
- R2: A qualified write (`ld_n`=0 and `wen_n`=0 at a rising `wclk`) stores `din`. Successive qualified writes go to the almost-empty bits [7:0], the almost-empty high bits, the almost-full bits [7:0] and the almost-full high bits, in that order. The new value shows on `ae_off`/`af_off` after that edge.
- R3: After the fourth qualified write, the next qualified write goes again to the almost-empty low byte.
- R4: A `wclk` edge without a qualified write changes neither offset and does not advance the write position.
- R5: `fifo_wr_en` is high exactly when `wen_n`=0 and `ld_n`=1. `fifo_rd_en` is high exactly when `ren_n`=0 and `ld_n`=1. Enables with `ld_n`=1 leave the offsets and the output register untouched.
- R6: A qualified read (`ld_n`=0 and `ren_n`=0 at a rising `rclk`) loads the output register with the byte at the read position, in the same four-step order as R2, wrapping after the fourth.
- R7: `dout` shows the output register while `oe_n`=0 and is high impedance while `oe_n`=1.
- R8: In a high-byte write, `din` bits at and above `OFS_W-8` are discarded. A high-byte readback returns those bits as 0.
- R9: An `rclk` edge without a qualified read leaves the output register and the read position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled synchronously in each domain |
| ld_n | input | 1 | Load select, active low: steers enables to the offset registers |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 8 | Write data byte |
| dout | output | 8 | Readback byte, high impedance when `oe_n` is high |
| ae_off | output | OFS_W | Almost-empty offset to the flag logic |
| af_off | output | OFS_W | Almost-full offset to the flag logic |
| fifo_wr_en | output | 1 | Write enable forwarded to the FIFO memory |
| fifo_rd_en | output | 1 | Read enable forwarded to the FIFO memory |

## Verification
The bench targets the position wrap after the fourth byte: a counter that saturated or reset would put a fifth write into the almost-full high byte. It interleaves idle and load-less enable cycles to catch a position counter that advances on the wrong qualifier, or a FIFO write that corrupts an offset. It writes all-ones high bytes to expose upper bits that are kept or read back non-zero. It also toggles the output enable to catch a `dout` that drives when it should float or floats when it should drive.

// File: rtl/ofs_pkg.sv
// Shared types for the flag offset register port.
// Assumes a byte-wide data path and exactly two offsets.
package ofs_pkg;
    localparam int BYTE_W = 8;

    // Byte positions in transfer order; the order is behaviour.
    typedef enum logic [1:0] {
        POS_AE_LO = 2'd0,
        POS_AE_HI = 2'd1,
        POS_AF_LO = 2'd2,
        POS_AF_HI = 2'd3
    } ofs_pos_e;

    // Next position, wrapping after the last byte.
    function automatic ofs_pos_e pos_next(input ofs_pos_e p);
        return ofs_pos_e'(p + 2'd1);
    endfunction
endpackage

// File: rtl/ofs_step_ptr.sv
// Byte-position counter for one clock domain.
// Advances one step per qualified transfer, wraps after four.
// Assumes rst_n is synchronous to clk.
module ofs_step_ptr
    import ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    output ofs_pos_e pos
);
    // Step on each qualified transfer, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= POS_AE_LO;
        else if (adv)
            pos <= pos_next(pos);
    end
endmodule

// File: rtl/ofs_wr_bank.sv
// Storage for the two offsets, written one byte per qualified write.
// Offset k owns positions 2k (low byte) and 2k+1 (high byte).
// Assumes 9 <= OFS_W <= 16; din bits above the offset width are dropped.
module ofs_wr_bank
    import ofs_pkg::*;
#(
    parameter int OFS_W   = 14,
    parameter int DEF_OFS = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  ofs_pos_e         pos,
    input  logic [BYTE_W-1:0] din,
    output logic [OFS_W-1:0] ae_off,
    output logic [OFS_W-1:0] af_off
);
    localparam int HI_W = OFS_W - BYTE_W;

    logic [OFS_W-1:0] regs [2];

    for (genvar k = 0; k < 2; k++) begin : g_ofs
        // Load the addressed byte of offset k, or its default on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[k] <= OFS_W'(DEF_OFS);
            else if (we && pos == ofs_pos_e'(2*k))
                regs[k][BYTE_W-1:0] <= din;
            else if (we && pos == ofs_pos_e'(2*k+1))
                regs[k][OFS_W-1:BYTE_W] <= din[HI_W-1:0];
        end
    end

    assign ae_off = regs[0];
    assign af_off = regs[1];
endmodule

// File: rtl/ofs_rd_sel.sv
// Readback output register: picks the offset byte at the read position
// on each qualified read and holds it otherwise.
// Assumes the offsets are static while a readback sequence runs.
module ofs_rd_sel
    import ofs_pkg::*;
#(
    parameter int OFS_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  ofs_pos_e          pos,
    input  logic [OFS_W-1:0]  ae_off,
    input  logic [OFS_W-1:0]  af_off,
    output logic [BYTE_W-1:0] q
);
    localparam int HI_W = OFS_W - BYTE_W;

    logic [BYTE_W-1:0] sel;

    // Pick the byte for the current position, upper bits zero-filled.
    always_comb begin
        unique case (pos)
            POS_AE_LO: sel = ae_off[BYTE_W-1:0];
            POS_AE_HI: sel = BYTE_W'(ae_off[OFS_W-1:BYTE_W]);
            POS_AF_LO: sel = af_off[BYTE_W-1:0];
            default:   sel = BYTE_W'(af_off[OFS_W-1:BYTE_W]);
        endcase
    end

    // Capture on a qualified read, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (re)
            q <= sel;
    end

    initial begin
        assert (HI_W >= 1 && HI_W <= BYTE_W)
            else $error("OFS_W must be 9..16");
    end
endmodule

// File: rtl/ofs_regport.sv
// Flag offset register port: byte-serial load in the write domain,
// byte-serial readback in the read domain, enable steering to memory.
// Assumes mrst_n is held low across at least one edge of each clock and
// that loads and readbacks are not overlapped.
module ofs_regport
    import ofs_pkg::*;
#(
    parameter int OFS_W   = 14,
    parameter int DEF_OFS = 127
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic              oe_n,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic [OFS_W-1:0]  ae_off,
    output logic [OFS_W-1:0]  af_off,
    output logic              fifo_wr_en,
    output logic              fifo_rd_en
);
    logic     wr_q, rd_q;
    ofs_pos_e wpos, rpos;
    logic [BYTE_W-1:0] out_q;

    // Qualify transfers to this port and steer the rest to memory.
    always_comb begin
        wr_q       = !ld_n && !wen_n;
        rd_q       = !ld_n && !ren_n;
        fifo_wr_en =  ld_n && !wen_n;
        fifo_rd_en =  ld_n && !ren_n;
    end

    ofs_step_ptr u_wptr (.clk(wclk), .rst_n(mrst_n), .adv(wr_q), .pos(wpos));
    ofs_step_ptr u_rptr (.clk(rclk), .rst_n(mrst_n), .adv(rd_q), .pos(rpos));

    ofs_wr_bank #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_bank (
        .clk(wclk), .rst_n(mrst_n), .we(wr_q), .pos(wpos), .din(din),
        .ae_off(ae_off), .af_off(af_off)
    );

    ofs_rd_sel #(.OFS_W(OFS_W)) u_rsel (
        .clk(rclk), .rst_n(mrst_n), .re(rd_q), .pos(rpos),
        .ae_off(ae_off), .af_off(af_off), .q(out_q)
    );

    // Drive the readback byte only while output enable is active.
    assign dout = oe_n ? 'z : out_q;
endmodule

// File: rtl/ofs_regport_chk.sv
// Assertion checker for ofs_regport; keeps its own transfer counters.
module ofs_regport_chk #(
    parameter int OFS_W   = 14,
    parameter int DEF_OFS = 127
) (
    input logic             wclk,
    input logic             rclk,
    input logic             mrst_n,
    input logic             ld_n,
    input logic             wen_n,
    input logic             ren_n,
    input logic [7:0]       din,
    input logic [OFS_W-1:0] ae_off,
    input logic [OFS_W-1:0] af_off,
    input logic             fifo_wr_en,
    input logic             fifo_rd_en,
    input logic [7:0]       out_q
);
    localparam int HI_W = OFS_W - 8;

    logic [1:0] wcnt, rcnt;
    logic wq, rq;
    assign wq = !ld_n && !wen_n;
    assign rq = !ld_n && !ren_n;

    // Count qualified writes modulo four.
    always_ff @(posedge wclk) begin
        if (!mrst_n) wcnt <= '0;
        else if (wq) wcnt <= wcnt + 2'd1;
    end

    // Count qualified reads modulo four.
    always_ff @(posedge rclk) begin
        if (!mrst_n) rcnt <= '0;
        else if (rq) rcnt <= rcnt + 2'd1;
    end

    // R1
    rst_default_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        !$past(mrst_n) |-> (ae_off == OFS_W'(DEF_OFS) && af_off == OFS_W'(DEF_OFS)));

    // R2
    ae_lo_load_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (wq && wcnt == 2'd0) |=> ae_off[7:0] == $past(din));

    // R3
    af_hi_then_wrap_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (wq && wcnt == 2'd3) |=> (af_off[OFS_W-1:8] == $past(din[HI_W-1:0])));

    // R4
    offset_hold_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        !wq |=> ($stable(ae_off) && $stable(af_off)));

    // R5
    mem_wr_route_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        fifo_wr_en |-> ld_n);

    // R5
    mem_rd_route_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        fifo_rd_en |-> ld_n);

    // R8
    hi_zero_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (rq && rcnt[0]) |=> ((out_q >> HI_W) == 8'd0));

    // R9
    out_hold_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        !rq |=> $stable(out_q));
endmodule

bind ofs_regport ofs_regport_chk #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .ld_n(ld_n), .wen_n(wen_n),
    .ren_n(ren_n), .din(din), .ae_off(ae_off), .af_off(af_off),
    .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en), .out_q(out_q)
);

// File: tb/tb_ofs_regport.sv
module tb_ofs_regport;
    localparam int OFS_W = 14;
    localparam int DEF   = 127;
    localparam int HI_W  = OFS_W - 8;

    logic wclk = 0, rclk = 0;
    logic mrst_n = 0, ld_n = 1, wen_n = 1, ren_n = 1, oe_n = 0;
    logic [7:0] din = 0;
    logic [7:0] dout;
    logic [OFS_W-1:0] ae_off, af_off;
    logic fifo_wr_en, fifo_rd_en;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model
    logic [OFS_W-1:0] m_ae, m_af;
    int m_wp, m_rp;
    logic [7:0] m_q;

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    ofs_regport #(.OFS_W(OFS_W), .DEF_OFS(DEF)) dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .ld_n(ld_n),
        .wen_n(wen_n), .ren_n(ren_n), .oe_n(oe_n), .din(din), .dout(dout),
        .ae_off(ae_off), .af_off(af_off),
        .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en)
    );

    function automatic logic [7:0] exp_byte(int p);
        case (p)
            0: return m_ae[7:0];
            1: return 8'(m_ae[OFS_W-1:8]);
            2: return m_af[7:0];
            default: return 8'(m_af[OFS_W-1:8]);
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(bit ld, bit we, logic [7:0] d);
        @(negedge wclk);
        ld_n = ~ld; wen_n = ~we; din = d;
        #1;
        chk("R5 fifo_wr_en", 32'(fifo_wr_en), 32'(we && !ld));
        @(posedge wclk);
        if (ld && we) begin
            case (m_wp)
                0: m_ae[7:0] = d;
                1: m_ae[OFS_W-1:8] = d[HI_W-1:0];
                2: m_af[7:0] = d;
                default: m_af[OFS_W-1:8] = d[HI_W-1:0];
            endcase
            m_wp = (m_wp + 1) % 4;
        end
        @(negedge wclk);
        wen_n = 1; ld_n = 1;
        chk("R2/R4 ae_off", 32'(ae_off), 32'(m_ae));
        chk("R2/R4 af_off", 32'(af_off), 32'(m_af));
    endtask

    task automatic do_read(bit ld, bit re, bit oe);
        @(negedge rclk);
        ld_n = ~ld; ren_n = ~re; oe_n = ~oe;
        #1;
        chk("R5 fifo_rd_en", 32'(fifo_rd_en), 32'(re && !ld));
        @(posedge rclk);
        if (ld && re) begin
            m_q = exp_byte(m_rp);
            m_rp = (m_rp + 1) % 4;
        end
        @(negedge rclk);
        ren_n = 1; ld_n = 1;
        if (oe) chk("R6/R9 dout", 32'(dout), 32'(m_q));
        else    chk("R7 dout float", {24'h0, dout}, {24'h0, 8'hzz});
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ae = OFS_W'(DEF); m_af = OFS_W'(DEF); m_wp = 0; m_rp = 0; m_q = 0;
        repeat (4) @(posedge rclk);
        @(negedge wclk); mrst_n = 1;
        @(negedge rclk);
        // R1 reset state
        chk("R1 ae_off", 32'(ae_off), DEF);
        chk("R1 af_off", 32'(af_off), DEF);
        chk("R1 dout", 32'(dout), 0);

        // R2 directed order, R8 all-ones high bytes
        do_write(1, 1, 8'h12);
        do_write(1, 1, 8'hFF);
        do_write(1, 1, 8'h34);
        do_write(1, 1, 8'hFF);
        chk("R8 ae upper", 32'(ae_off), 32'h3F12);
        chk("R8 af upper", 32'(af_off), 32'h3F34);
        // R3 wrap to almost-empty low byte
        do_write(1, 1, 8'hA5);
        chk("R3 wrap", 32'(ae_off[7:0]), 32'hA5);
        // R4 idle and R5 memory-only writes
        do_write(1, 0, 8'h00);
        do_write(0, 1, 8'h77);
        do_write(1, 1, 8'h01);
        chk("R4 no advance", 32'(ae_off), 32'h01A5);
        do_write(1, 1, 8'h02);
        do_write(1, 1, 8'h03);
        // R6 readback order, R8 high byte zero
        for (int i = 0; i < 5; i++) do_read(1, 1, 1);
        // R7 float, R9 hold
        do_read(1, 0, 0);
        do_read(0, 1, 1);

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 1);
            if (op == 0)
                do_write($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                         8'($urandom_range(0, 255)));
            else
                do_read($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                        $urandom_range(0, 4) != 0);
        end

        // R1 reset again mid-sequence
        @(negedge rclk); mrst_n = 0;
        repeat (3) @(posedge rclk);
        @(negedge wclk); mrst_n = 1;
        m_ae = OFS_W'(DEF); m_af = OFS_W'(DEF); m_wp = 0; m_rp = 0; m_q = 0;
        @(negedge rclk);
        chk("R1 ae_off again", 32'(ae_off), DEF);
        chk("R1 dout again", 32'(dout), 0);
        do_read(1, 1, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule